// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block is the control half of one DMA channel. Software does not program an address and a length. It builds a linked list of 32-byte descriptors in memory, writes the address of the first one into the channel, and then writes a doorbell. The sequencer reads the eight words of each descriptor over a word-wide memory read port and checks the valid flag. It passes the source address, destination address and byte count to an external data mover through a start/done handshake. It then performs the status write-back the descriptor asks for, optionally clears the descriptor's valid flag in memory, posts a completion interrupt and moves on to the next descriptor.

The chain stops at the first descriptor whose valid flag is clear, or at one whose type is not the standard type. The channel then reports itself halted and waits for another doorbell, which resumes fetching from the descriptor it stopped on. Moving the data, detecting peripheral requests and arbitrating the bus are left to neighbouring blocks.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the status register reads 1 (halted), the descriptor pointer, byte count and irq registers read 0, `irq_o` is low and no memory or mover request is raised.
- R2: A doorbell write (register index 3) while halted with config bit 0 set fetches the eight descriptor words, one read at a time, at pointer+0, +4, ... +28. A write to the descriptor pointer (index 1) clears its low 5 bits.
- R3: A doorbell written while config bit 0 is clear starts no fetch and the channel stays halted, but status bit 2 (doorbell pushed) becomes 1.
- R4: A fetched descriptor with cmd0 bit 31 clear starts no transfer and halts the channel (status bit 0 set, bits 1 and 2 cleared). The pointer stays on it, and the next doorbell fetches it again.
- R5: A valid descriptor whose type field (cmd0 bits 14:13) is not 0 halts the channel with status bit 3 (error) set. The next accepted doorbell clears that bit.
- R6: For a valid standard descriptor, `mv_start` is held until `mv_done`, with `mv_src` = {cmd1[31:28], source0 (word 2)}, `mv_dst` = {cmd1[27:24], dest0 (word 4)}, `mv_len` = cmd1[21:0] and `mv_be` = config bits 2:1.
- R7: After the transfer, cmd0 bits 1:0 select the write-back: 0 none, 1 the channel status register, 2 cmd0 with bit 31 cleared, 3 the mover's residual count. The write goes to the status pointer (index 2) when cmd0 bit 4 is set, and to descriptor+24 when it is clear.
- R8: When cmd0 bit 2 is set, cmd0 with bit 31 cleared is written to descriptor+0, after any status write-back.
- R9: After each completed descriptor, the pointer becomes next-word (word 7) bits 26:0 shifted left by 5. This value is readable at index 1 and is the next fetch address.
- R10: Every completed descriptor sets irq register (index 4) bit 0. `irq_o` rises only for descriptors with cmd0 bit 8 set. Writing 1 to bit 0 of index 4 clears both.
- R11: The byte-count register (index 6) holds the residual count the mover reported for the last completed descriptor.
- R12: While the chain runs, status reads bit 0 = 0, bit 1 = 1 (descriptor valid) and bit 2 = 1 (doorbell pushed). While halted, no memory or mover request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 config, 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 irq, 5 status, 6 byte count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mrd_req | output | 1 | Memory read request, held until acknowledged |
| mrd_addr | output | 32 | Memory read byte address |
| mrd_ack | input | 1 | Read acknowledge, `mrd_data` valid |
| mrd_data | input | 32 | Read data |
| mwr_req | output | 1 | Memory write request, held until acknowledged |
| mwr_addr | output | 32 | Memory write byte address |
| mwr_data | output | 32 | Memory write data |
| mwr_ack | input | 1 | Write acknowledge |
| mv_start | output | 1 | Transfer request to the data mover, held until done |
| mv_src | output | 36 | Extended source address |
| mv_dst | output | 36 | Extended destination address |
| mv_len | output | 22 | Byte count |
| mv_be | output | 2 | Big-endian selects {source, destination} |
| mv_done | input | 1 | Transfer finished |
| mv_residue | input | 22 | Bytes left untransferred, valid with `mv_done` |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions check three things on every cycle. A memory read, memory write or transfer request keeps its address and payload stable until it is acknowledged. A halted channel raises no request. The interrupt output is never high without the pending bit. Only the bench scenarios can show how the chain is walked: the exact fetch addresses, how each write-back mode and the clear-valid write are chosen and ordered, following the next pointer, halting on an invalid or non-standard descriptor and resuming from the same place, and interrupts being raised only for descriptors that enable them.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [2:0] {
    ST_HALT, ST_LOAD, ST_FETCH, ST_CHECK, ST_MOVE, ST_STAT, ST_CLRV, ST_NEXT
  } seq_st_e;

  // register indices
  localparam logic [2:0] RA_CFG  = 3'd0;
  localparam logic [2:0] RA_DPTR = 3'd1;
  localparam logic [2:0] RA_SPTR = 3'd2;
  localparam logic [2:0] RA_BELL = 3'd3;
  localparam logic [2:0] RA_IRQ  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_BCNT = 3'd6;

  // descriptor word slots
  localparam int W_CMD0 = 0;
  localparam int W_CMD1 = 1;
  localparam int W_SRC0 = 2;
  localparam int W_DST0 = 4;
  localparam int W_STAT = 6;
  localparam int W_NXT  = 7;

  // cmd0 bit positions
  localparam int C0_VALID = 31;
  localparam int C0_IE    = 8;
  localparam int C0_SPSEL = 4;
  localparam int C0_CLRV  = 2;
  localparam int C0_TYPE  = 13;

  localparam logic [1:0] WB_NONE  = 2'd0;
  localparam logic [1:0] WB_STAT  = 2'd1;
  localparam logic [1:0] WB_CMD   = 2'd2;
  localparam logic [1:0] WB_COUNT = 2'd3;

endpackage

// File: rtl/dds_fetch.sv
module dds_fetch #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NW  = 8,
  parameter int BCW = 22,
  parameter int XW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base,
  output logic              mrd_req,
  output logic [AW-1:0]     mrd_addr,
  input  logic              mrd_ack,
  input  logic [DW-1:0]     mrd_data,
  output logic              done,
  output logic [DW-1:0]     cmd0,
  output logic [2*XW-1:0]   cmd1_up,
  output logic [BCW-1:0]    cmd1_len,
  output logic [DW-1:0]     src0,
  output logic [DW-1:0]     dst0,
  output logic [AW-6:0]     nxt
);
  import dds_pkg::*;

  localparam int CW = $clog2(NW);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] base_q;
  logic          last, take;

  assign last     = (cnt_q == CW'(NW-1));
  assign take     = busy_q && mrd_ack;
  assign done     = take && last;
  assign mrd_req  = busy_q;
  assign mrd_addr = base_q + {{(AW-CW-2){1'b0}}, cnt_q, 2'b00};

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (take) begin
      cnt_d = cnt_q + CW'(1);
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (start) base_q <= base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd0 <= '0; cmd1_up <= '0; cmd1_len <= '0;
      src0 <= '0; dst0 <= '0; nxt <= '0;
    end else if (take) begin
      case (int'(cnt_q))
        W_CMD0: cmd0 <= mrd_data;
        W_CMD1: begin
          cmd1_up  <= mrd_data[DW-1 -: 2*XW];
          cmd1_len <= mrd_data[BCW-1:0];
        end
        W_SRC0: src0 <= mrd_data;
        W_DST0: dst0 <= mrd_data;
        W_NXT:  nxt  <= mrd_data[AW-6:0];
        default: ;
      endcase
    end
  end

  // R2: a pending read keeps its address until acknowledged
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req && !mrd_ack) |=> (mrd_req && $stable(mrd_addr)));

endmodule

// File: rtl/dds_regs.sv
module dds_regs #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BCW = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ev_valid,
  input  logic            ev_halt,
  input  logic            ev_err,
  input  logic            ev_done,
  input  logic            ev_ie,
  input  logic [AW-6:0]   ev_nptr,
  input  logic [BCW-1:0]  ev_res,
  output logic            db_go,
  output logic            halted,
  output logic [1:0]      cfg_be,
  output logic [AW-1:0]   dptr,
  output logic [AW-1:0]   sptr,
  output logic [DW-1:0]   stat_word,
  output logic            irq_o
);
  import dds_pkg::*;

  logic [2:0]     cfg_q, cfg_d;
  logic [AW-6:0]  dptr_q, dptr_d;
  logic [AW-3:0]  sptr_q, sptr_d;
  logic           halt_q, halt_d, vld_q, vld_d, dbf_q, dbf_d, err_q, err_d;
  logic           pend_q, pend_d, irq_q, irq_d;
  logic [BCW-1:0] bcnt_q, bcnt_d;
  logic           wr_cfg, wr_dptr, wr_sptr, wr_bell, clr_irq;

  assign wr_cfg  = reg_wr && (reg_addr == RA_CFG);
  assign wr_dptr = reg_wr && (reg_addr == RA_DPTR);
  assign wr_sptr = reg_wr && (reg_addr == RA_SPTR);
  assign wr_bell = reg_wr && (reg_addr == RA_BELL);
  assign clr_irq = reg_wr && (reg_addr == RA_IRQ) && reg_wdata[0];
  assign db_go   = wr_bell && cfg_q[0] && halt_q;

  always_comb begin
    cfg_d  = wr_cfg ? reg_wdata[2:0] : cfg_q;
    sptr_d = wr_sptr ? reg_wdata[AW-1:2] : sptr_q;
    dptr_d = dptr_q;
    if (wr_dptr)      dptr_d = reg_wdata[AW-1:5];
    else if (ev_done) dptr_d = ev_nptr;
    halt_d = db_go ? 1'b0 : (ev_halt ? 1'b1 : halt_q);
    vld_d  = ev_halt ? 1'b0 : (ev_valid ? 1'b1 : vld_q);
    dbf_d  = wr_bell ? 1'b1 : (ev_halt ? 1'b0 : dbf_q);
    err_d  = db_go ? 1'b0 : ((ev_halt && ev_err) ? 1'b1 : err_q);
    pend_d = ev_done ? 1'b1 : (clr_irq ? 1'b0 : pend_q);
    irq_d  = (ev_done && ev_ie) ? 1'b1 : (clr_irq ? 1'b0 : irq_q);
    bcnt_d = ev_done ? ev_res : bcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; dptr_q <= '0; sptr_q <= '0;
      halt_q <= 1'b1; vld_q <= 1'b0; dbf_q <= 1'b0; err_q <= 1'b0;
      pend_q <= 1'b0; irq_q <= 1'b0; bcnt_q <= '0;
    end else begin
      cfg_q <= cfg_d; dptr_q <= dptr_d; sptr_q <= sptr_d;
      halt_q <= halt_d; vld_q <= vld_d; dbf_q <= dbf_d; err_q <= err_d;
      pend_q <= pend_d; irq_q <= irq_d; bcnt_q <= bcnt_d;
    end
  end

  assign halted    = halt_q;
  assign cfg_be    = cfg_q[2:1];
  assign dptr      = {dptr_q, 5'b0};
  assign sptr      = {sptr_q, 2'b0};
  assign stat_word = {{(DW-4){1'b0}}, err_q, dbf_q, vld_q, halt_q};
  assign irq_o     = irq_q;

  always_comb begin
    case (reg_addr)
      RA_CFG:  reg_rdata = {{(DW-3){1'b0}}, cfg_q};
      RA_DPTR: reg_rdata = DW'(dptr);
      RA_SPTR: reg_rdata = DW'(sptr);
      RA_IRQ:  reg_rdata = {{(DW-1){1'b0}}, pend_q};
      RA_STAT: reg_rdata = stat_word;
      RA_BCNT: reg_rdata = DW'(bcnt_q);
      default: reg_rdata = '0;
    endcase
  end

  // R10: the interrupt line never stands without the pending bit
  p_irq_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> pend_q);

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NW  = 8,
  parameter int BCW = 22,
  parameter int XW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             mrd_req,
  output logic [AW-1:0]    mrd_addr,
  input  logic             mrd_ack,
  input  logic [DW-1:0]    mrd_data,
  output logic             mwr_req,
  output logic [AW-1:0]    mwr_addr,
  output logic [DW-1:0]    mwr_data,
  input  logic             mwr_ack,
  output logic             mv_start,
  output logic [XW+DW-1:0] mv_src,
  output logic [XW+DW-1:0] mv_dst,
  output logic [BCW-1:0]   mv_len,
  output logic [1:0]       mv_be,
  input  logic             mv_done,
  input  logic [BCW-1:0]   mv_residue,
  output logic             irq_o
);
  import dds_pkg::*;

  localparam logic [AW-1:0] STAT_OFS = AW'(W_STAT * (DW / 8));

  seq_st_e        st_q, st_d;
  logic [BCW-1:0] res_q;
  logic           f_start, f_done;
  logic [DW-1:0]  cmd0, src0, dst0;
  logic [2*XW-1:0] cmd1_up;
  logic [BCW-1:0] cmd1_len;
  logic [AW-6:0]  nxt;
  logic           ev_valid, ev_halt, ev_err, ev_done;
  logic           db_go, halted;
  logic [AW-1:0]  dptr, sptr;
  logic [DW-1:0]  stat_word, cmd0_nv;
  logic [1:0]     wb_mode;
  logic           clrv;

  dds_fetch #(.AW(AW), .DW(DW), .NW(NW), .BCW(BCW), .XW(XW)) u_fetch (
    .clk, .rst_n, .start(f_start), .base(dptr),
    .mrd_req, .mrd_addr, .mrd_ack, .mrd_data, .done(f_done),
    .cmd0, .cmd1_up, .cmd1_len, .src0, .dst0, .nxt
  );

  dds_regs #(.AW(AW), .DW(DW), .BCW(BCW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ev_valid, .ev_halt, .ev_err, .ev_done, .ev_ie(cmd0[C0_IE]),
    .ev_nptr(nxt), .ev_res(res_q), .db_go, .halted, .cfg_be(mv_be),
    .dptr, .sptr, .stat_word, .irq_o
  );

  assign wb_mode = cmd0[1:0];
  assign clrv    = cmd0[C0_CLRV];
  assign cmd0_nv = cmd0 & ~(DW'(1) << C0_VALID);

  always_comb begin
    st_d     = st_q;
    f_start  = 1'b0;
    ev_valid = 1'b0;
    ev_halt  = 1'b0;
    ev_err   = 1'b0;
    ev_done  = 1'b0;
    case (st_q)
      ST_HALT:  if (db_go) st_d = ST_LOAD;
      ST_LOAD:  begin f_start = 1'b1; st_d = ST_FETCH; end
      ST_FETCH: if (f_done) st_d = ST_CHECK;
      ST_CHECK: begin
        if (!cmd0[C0_VALID]) begin
          ev_halt = 1'b1; st_d = ST_HALT;
        end else if (cmd0[C0_TYPE +: 2] != 2'd0) begin
          ev_halt = 1'b1; ev_err = 1'b1; st_d = ST_HALT;
        end else begin
          ev_valid = 1'b1; st_d = ST_MOVE;
        end
      end
      ST_MOVE: if (mv_done) begin
        if (wb_mode != WB_NONE) st_d = ST_STAT;
        else if (clrv)          st_d = ST_CLRV;
        else                    st_d = ST_NEXT;
      end
      ST_STAT: if (mwr_ack) st_d = clrv ? ST_CLRV : ST_NEXT;
      ST_CLRV: if (mwr_ack) st_d = ST_NEXT;
      ST_NEXT: begin ev_done = 1'b1; st_d = ST_LOAD; end
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HALT;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if ((st_q == ST_MOVE) && mv_done) res_q <= mv_residue;
  end

  assign mv_start = (st_q == ST_MOVE);
  assign mv_src   = {cmd1_up[2*XW-1:XW], src0};
  assign mv_dst   = {cmd1_up[XW-1:0], dst0};
  assign mv_len   = cmd1_len;

  assign mwr_req = (st_q == ST_STAT) || (st_q == ST_CLRV);

  always_comb begin
    mwr_addr = dptr;
    mwr_data = cmd0_nv;
    if (st_q == ST_STAT) begin
      mwr_addr = cmd0[C0_SPSEL] ? sptr : (dptr + STAT_OFS);
      case (wb_mode)
        WB_STAT:  mwr_data = stat_word;
        WB_COUNT: mwr_data = DW'(res_q);
        default:  mwr_data = cmd0_nv;
      endcase
    end
  end

  // R6: transfer request and its length stay put until the mover finishes
  p_mv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_start && !mv_done) |=> (mv_start && $stable(mv_len) && $stable(mv_src)));

  // R7: a write-back keeps address and data until acknowledged
  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mwr_req && !mwr_ack) |=> (mwr_req && $stable(mwr_addr) && $stable(mwr_data)));

  // R12: a halted channel is silent on every request line
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mv_start && !mwr_req && !mrd_req));

endmodule

// File: tb/test_dma_desc_seq.sv
`timescale 1ns/1ps
module test_dma_desc_seq;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mrd_req, mrd_ack, mwr_req, mwr_ack;
  logic [31:0] mrd_addr, mrd_data, mwr_addr, mwr_data;
  logic        mv_start, mv_done, irq_o;
  logic [35:0] mv_src, mv_dst;
  logic [21:0] mv_len, mv_residue;
  logic [1:0]  mv_be;

  dma_desc_seq i_dma_desc_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mrd_req, .mrd_addr, .mrd_ack, .mrd_data,
    .mwr_req, .mwr_addr, .mwr_data, .mwr_ack,
    .mv_start, .mv_src, .mv_dst, .mv_len, .mv_be, .mv_done, .mv_residue,
    .irq_o
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct { logic [35:0] src; logic [35:0] dst; logic [21:0] len;
                   logic [1:0] be; logic [21:0] res; } mv_item_t;
  typedef struct { logic [31:0] addr; logic [31:0] data; } wr_item_t;

  mv_item_t    mv_q[$];
  wr_item_t    wr_q[$];
  logic [31:0] rd_q[$];
  logic [31:0] mem [64];
  int          n_run, n_fail;
  int          mcnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: one-cycle registered acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd_ack <= 1'b0; mrd_data <= '0; mwr_ack <= 1'b0;
    end else begin
      mrd_ack  <= mrd_req && !mrd_ack;
      mrd_data <= mem[mrd_addr[7:2]];
      mwr_ack  <= mwr_req && !mwr_ack;
      if (mwr_req && !mwr_ack) mem[mwr_addr[7:2]] <= mwr_data;
    end
  end

  // data mover model: done after three cycles, residue from the expected item
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_done <= 1'b0; mv_residue <= '0; mcnt <= 0;
    end else if (mv_start && !mv_done) begin
      if (mcnt == 2) begin
        mv_done <= 1'b1; mcnt <= 0;
        mv_residue <= (mv_q.size() > 0) ? mv_q[0].res : 22'd0;
      end else mcnt <= mcnt + 1;
    end else mv_done <= 1'b0;
  end

  // scoreboard monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && mrd_req && mrd_ack) begin
      if (rd_q.size() == 0) chk(0, "R2/R3", "unexpected fetch", mrd_addr, 0);
      else begin
        logic [31:0] e;
        e = rd_q.pop_front();
        chk(mrd_addr == e, "R2/R9", "fetch address", mrd_addr, e);
      end
    end
    if (rst_n && mwr_req && mwr_ack) begin
      if (wr_q.size() == 0) chk(0, "R7/R8", "unexpected write", mwr_addr, 0);
      else begin
        wr_item_t w;
        w = wr_q.pop_front();
        chk(mwr_addr == w.addr, "R7/R8", "write address", mwr_addr, w.addr);
        chk(mwr_data == w.data, "R7/R8", "write data", mwr_data, w.data);
      end
    end
    if (rst_n && mv_start && mv_done) begin
      if (mv_q.size() == 0) chk(0, "R4/R5", "unexpected transfer", mv_len, 0);
      else begin
        mv_item_t m;
        m = mv_q.pop_front();
        chk(mv_src == m.src, "R6", "mover source", mv_src, m.src);
        chk(mv_dst == m.dst, "R6", "mover dest", mv_dst, m.dst);
        chk(mv_len == m.len, "R6", "mover length", mv_len, m.len);
        chk(mv_be == m.be, "R6", "mover endian", mv_be, m.be);
      end
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic push_fetch(input logic [31:0] base);
    for (int k = 0; k < 8; k++) rd_q.push_back(base + 32'(4 * k));
  endtask

  task automatic push_mv(input logic [35:0] s, input logic [35:0] d,
                         input logic [21:0] l, input logic [1:0] b, input logic [21:0] r);
    mv_item_t m;
    m.src = s; m.dst = d; m.len = l; m.be = b; m.res = r;
    mv_q.push_back(m);
  endtask

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d);
    wr_item_t w;
    w.addr = a; w.data = d;
    wr_q.push_back(w);
  endtask

  task automatic put_desc(input int base, input logic [31:0] c0, input logic [31:0] c1,
                          input logic [31:0] s0, input logic [31:0] d0, input logic [31:0] np);
    @(negedge clk);
    mem[base/4 + 0] <= c0; mem[base/4 + 1] <= c1; mem[base/4 + 2] <= s0;
    mem[base/4 + 3] <= 32'hA5A5_0003; mem[base/4 + 4] <= d0;
    mem[base/4 + 5] <= 32'hA5A5_0005; mem[base/4 + 6] <= 32'hA5A5_0006;
    mem[base/4 + 7] <= np;
  endtask

  task automatic wait_halt();
    logic [31:0] s;
    s = 32'd0;
    while (s[0] == 1'b0) reg_read(3'd5, s);
  endtask

  task automatic queues_empty(input string req);
    chk(rd_q.size() == 0, req, "fetches left", rd_q.size(), 0);
    chk(mv_q.size() == 0, req, "transfers left", mv_q.size(), 0);
    chk(wr_q.size() == 0, req, "writes left", wr_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    n_run = 0; n_fail = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    for (int i = 0; i < 64; i++) mem[i] <= 32'd0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_read(3'd5, v); chk(v == 32'h1, "R1", "status", v, 1);
    reg_read(3'd1, v); chk(v == 32'h0, "R1", "descriptor pointer", v, 0);
    reg_read(3'd6, v); chk(v == 32'h0, "R1", "byte count", v, 0);
    reg_read(3'd4, v); chk(v == 32'h0, "R1", "irq reg", v, 0);
    chk(!irq_o && !mrd_req && !mwr_req && !mv_start, "R1", "outputs idle",
        {irq_o, mrd_req, mwr_req, mv_start}, 0);

    // R3 doorbell with channel disabled
    reg_write(3'd0, 32'h0);
    reg_write(3'd1, 32'h20);
    reg_write(3'd3, 32'h0);
    repeat (20) @(negedge clk);
    reg_read(3'd5, v); chk(v == 32'h5, "R3", "status after disabled doorbell", v, 5);

    // R2 pointer alignment
    reg_write(3'd1, 32'h27);
    reg_read(3'd1, v); chk(v == 32'h20, "R2", "pointer low bits cleared", v, 32'h20);

    // chain of three descriptors ending on an invalid one
    put_desc(32'h20, 32'h8000_0101, 32'h5300_0010, 32'h1000, 32'h2000, 32'h2);
    put_desc(32'h40, 32'h8000_0016, 32'h0000_0040, 32'h3000, 32'h4000, 32'h3);
    put_desc(32'h60, 32'h8000_0003, 32'h0000_0080, 32'h5000, 32'h6000, 32'h4);
    put_desc(32'h80, 32'h0000_0000, 32'h0000_0008, 32'h7000, 32'h7100, 32'h5);
    reg_write(3'd2, 32'hF0);
    reg_write(3'd0, 32'h7);
    push_fetch(32'h20);
    push_mv({4'h5, 32'h1000}, {4'h3, 32'h2000}, 22'h10, 2'b11, 22'h0);
    push_wr(32'h38, 32'h6);                       // R7 mode 1, descriptor stat word
    push_fetch(32'h40);
    push_mv({4'h0, 32'h3000}, {4'h0, 32'h4000}, 22'h40, 2'b11, 22'h0);
    push_wr(32'hF0, 32'h16);                      // R7 mode 2 via status pointer
    push_wr(32'h40, 32'h16);                      // R8 clear valid
    push_fetch(32'h60);
    push_mv({4'h0, 32'h5000}, {4'h0, 32'h6000}, 22'h80, 2'b11, 22'h24);
    push_wr(32'h78, 32'h24);                      // R7 mode 3 residue
    push_fetch(32'h80);
    reg_write(3'd3, 32'h1);
    while (!mv_start) @(negedge clk);
    reg_read(3'd5, v); chk(v == 32'h6, "R12", "status while running", v, 6);
    wait_halt();
    repeat (2) @(negedge clk);
    reg_read(3'd5, v); chk(v == 32'h1, "R4", "status after invalid descriptor", v, 1);
    reg_read(3'd1, v); chk(v == 32'h80, "R9", "pointer follows chain", v, 32'h80);
    reg_read(3'd6, v); chk(v == 32'h24, "R11", "byte count residue", v, 32'h24);
    reg_read(3'd4, v); chk(v == 32'h1, "R10", "irq pending", v, 1);
    chk(irq_o == 1'b1, "R10", "irq output after IE descriptor", irq_o, 1);
    chk(mem[16] == 32'h16, "R8", "memory cmd0 valid cleared", mem[16], 32'h16);
    queues_empty("R6/R7");

    // R10 clear
    reg_write(3'd4, 32'h1);
    reg_read(3'd4, v); chk(v == 32'h0, "R10", "irq pending cleared", v, 0);
    chk(irq_o == 1'b0, "R10", "irq output cleared", irq_o, 0);

    // R4 resume from same descriptor, then R5 literal type error
    put_desc(32'h80, 32'h8000_0000, 32'h0000_0008, 32'h7000, 32'h7100, 32'h5);
    put_desc(32'hA0, 32'h8000_2000, 32'h0000_0004, 32'h7200, 32'h7300, 32'h6);
    reg_write(3'd0, 32'h1);
    push_fetch(32'h80);
    push_mv({4'h0, 32'h7000}, {4'h0, 32'h7100}, 22'h8, 2'b00, 22'h0);
    push_fetch(32'hA0);
    reg_write(3'd3, 32'h1);
    wait_halt();
    repeat (2) @(negedge clk);
    reg_read(3'd5, v); chk(v == 32'h9, "R5", "status error halt", v, 9);
    reg_read(3'd1, v); chk(v == 32'hA0, "R9", "pointer on bad descriptor", v, 32'hA0);
    reg_read(3'd4, v); chk(v == 32'h1, "R10", "irq pending without IE", v, 1);
    chk(irq_o == 1'b0, "R10", "no irq output without IE", irq_o, 0);
    reg_read(3'd6, v); chk(v == 32'h0, "R11", "byte count zero residue", v, 0);
    queues_empty("R5");

    // R5 error cleared by doorbell, R4 invalid halts without error
    put_desc(32'hA0, 32'h0000_0000, 32'h0000_0004, 32'h7200, 32'h7300, 32'h6);
    push_fetch(32'hA0);
    reg_write(3'd3, 32'h1);
    wait_halt();
    repeat (2) @(negedge clk);
    reg_read(3'd5, v); chk(v == 32'h1, "R5", "error cleared on restart", v, 1);
    queues_empty("R4");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule